// File: doc/BRIEF.md
# Per-Thread Virtual-Time Deadline Calculator

This block gives every memory request a deadline: the virtual time at which that request would complete if its thread owned a private memory system running at a fraction phi of the real bandwidth. For each thread it keeps one finish-time register per bank and one for the shared data channel. Each register records when that private resource becomes free for the next request. A request arrives with a thread number, a bank number, a command kind and an arrival timestamp. The block then moves the bank and channel clocks of that thread forward and reports the resulting finish time one cycle later.

Software sets phi through a per-thread multiplier equal to 1/phi in unsigned 8.8 fixed point. Each service cost comes from SDRAM timing parameters. It is multiplied by that factor and rounded up to a whole cycle. The register update is committed on the same clock edge that accepts the request, so requests issued back to back see each other's effect. A downstream scheduler uses the deadlines to order requests. Choosing the request is not part of this block.

Top module: `vt_deadline_calc`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) clears `dl_valid`, `dl_time` and every bank and channel finish-time register to zero, so the first request after reset starts at its arrival time.
- R2: `dl_valid` is high in the cycle after each cycle with `req_valid` high and low otherwise; `dl_time` keeps its value in cycles that follow a cycle without a request.
- R3: The bank start time is the larger of `req_arrival` and that thread's finish-time register for `req_bank`; the bank finish time is the bank start time plus the scaled bank cost, and it is written back to that bank register.
- R4: Command codes on `req_cmd`: 0 activate, 1 read, 2 write, 3 precharge. Unscaled bank costs with default parameters: activate T_RCD=5, read T_CL=5, write T_WL=4, precharge T_RP+(T_RAS-T_RCD-T_CL)=13.
- R5: Thread t's multiplier is `share_inv[16*t +: 16]` (8.8 format, 0x0100 = 1.0). A scaled cost is ceil(cost*multiplier/256), and a multiplier of 0 gives a cost of 0.
- R6: For read and write, the channel start time is the larger of the bank finish time and the thread's channel register. The channel finish time is the channel start time plus the scaled channel cost BURST_HALF=4. It is written to the channel register, and it is the deadline.
- R7: Activate and precharge have no channel cost. They leave the channel register unchanged, and their deadline is the bank finish time.
- R8: A request changes only the registers of its own thread; other threads' bank and channel registers are untouched.
- R9: Requests on consecutive cycles chain: each one sees the registers as updated by the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| share_inv | input | NUM_THREADS*16 | Per-thread 1/phi multiplier, 8.8 fixed point |
| req_valid | input | 1 | Request present this cycle |
| req_thread | input | THR_W | Thread number |
| req_bank | input | BANK_W | Bank number |
| req_cmd | input | 2 | Command kind (0 act, 1 read, 2 write, 3 precharge) |
| req_arrival | input | TIME_W | Arrival timestamp |
| dl_valid | output | 1 | Deadline valid |
| dl_time | output | TIME_W | Virtual finish-time deadline |

## Verification
A corrupted bank or channel register does not show until the next request that reads it. That request's deadline then comes out wrong in the following cycle. The back-to-back table therefore reuses banks and channels across threads, so a stale, wrongly indexed or wrongly updated register changes a later deadline within one or two requests. Rounding, zero multipliers and reset in the middle of a run each get a directed request whose deadline differs from the value a faulty register update or scaling would produce.

// File: rtl/vt_pkg.sv
package vt_pkg;

    typedef enum logic [1:0] {
        CMD_ACT = 2'd0,
        CMD_RD  = 2'd1,
        CMD_WR  = 2'd2,
        CMD_PRE = 2'd3
    } vt_cmd_e;

endpackage

// File: rtl/vt_scale.sv
module vt_scale #(
    parameter int COST_W = 8,
    parameter int MULT_W = 16,
    parameter int FRAC_W = 8,
    parameter int TIME_W = 16
) (
    input  logic [COST_W-1:0] cost,
    input  logic [MULT_W-1:0] mult,
    output logic [TIME_W-1:0] scaled
);
    localparam int PROD_W = COST_W + MULT_W;
    localparam logic [PROD_W:0] ROUND_UP = (PROD_W+1)'((1 << FRAC_W) - 1);

    logic [PROD_W:0] sum;
    logic [PROD_W:0] shifted;

    always_comb begin
        sum     = (PROD_W+1)'(cost * mult) + ROUND_UP;
        shifted = sum >> FRAC_W;
        scaled  = TIME_W'(shifted);
    end
endmodule

// File: rtl/vt_state.sv
module vt_state #(
    parameter int NUM_THREADS = 2,
    parameter int NUM_BANKS   = 4,
    parameter int TIME_W      = 16,
    parameter int THR_W       = 1,
    parameter int BANK_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [THR_W-1:0]  sel_thread,
    input  logic [BANK_W-1:0] sel_bank,
    output logic [TIME_W-1:0] bank_q,
    output logic [TIME_W-1:0] chan_q,
    input  logic              bank_we,
    input  logic              chan_we,
    input  logic [TIME_W-1:0] bank_d,
    input  logic [TIME_W-1:0] chan_d
);
    logic [TIME_W-1:0] bank_r [NUM_THREADS][NUM_BANKS];
    logic [TIME_W-1:0] chan_r [NUM_THREADS];

    assign bank_q = bank_r[sel_thread][sel_bank];
    assign chan_q = chan_r[sel_thread];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < NUM_THREADS; t++) begin
                chan_r[t] <= '0;
                for (int b = 0; b < NUM_BANKS; b++) begin
                    bank_r[t][b] <= '0;
                end
            end
        end else begin
            if (bank_we) bank_r[sel_thread][sel_bank] <= bank_d;
            if (chan_we) chan_r[sel_thread] <= chan_d;
        end
    end
endmodule

// File: rtl/vt_deadline_calc.sv
module vt_deadline_calc #(
    parameter int NUM_THREADS = 2,
    parameter int NUM_BANKS   = 4,
    parameter int TIME_W      = 16,
    parameter int MULT_W      = 16,
    parameter int FRAC_W      = 8,
    parameter int COST_W      = 8,
    parameter int T_RCD       = 5,
    parameter int T_CL        = 5,
    parameter int T_WL        = 4,
    parameter int T_RP        = 5,
    parameter int T_RAS       = 18,
    parameter int BURST_HALF  = 4,
    localparam int THR_W  = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_THREADS*MULT_W-1:0] share_inv,
    input  logic                          req_valid,
    input  logic [THR_W-1:0]              req_thread,
    input  logic [BANK_W-1:0]             req_bank,
    input  logic [1:0]                    req_cmd,
    input  logic [TIME_W-1:0]             req_arrival,
    output logic                          dl_valid,
    output logic [TIME_W-1:0]             dl_time
);
    import vt_pkg::*;

    localparam logic [COST_W-1:0] COST_ACT  = COST_W'(T_RCD);
    localparam logic [COST_W-1:0] COST_RD   = COST_W'(T_CL);
    localparam logic [COST_W-1:0] COST_WR   = COST_W'(T_WL);
    localparam logic [COST_W-1:0] COST_PRE  = COST_W'(T_RP + (T_RAS - T_RCD - T_CL));
    localparam logic [COST_W-1:0] COST_BUS  = COST_W'(BURST_HALF);

    // Per-thread multiplier unpacking
    logic [MULT_W-1:0] mult_arr [NUM_THREADS];
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_mult
        assign mult_arr[t] = share_inv[t*MULT_W +: MULT_W];
    end

    vt_cmd_e           cmd;
    logic [MULT_W-1:0] mult;
    logic [COST_W-1:0] bank_cost;
    logic [COST_W-1:0] chan_cost;
    logic              uses_chan;
    logic [TIME_W-1:0] bank_scaled, chan_scaled;
    logic [TIME_W-1:0] bank_prev, chan_prev;
    logic [TIME_W-1:0] bank_start, bank_fin;
    logic [TIME_W-1:0] chan_start, chan_fin;
    logic [TIME_W-1:0] deadline;

    assign cmd  = vt_cmd_e'(req_cmd);
    assign mult = mult_arr[req_thread];

    always_comb begin
        unique case (cmd)
            CMD_ACT: begin bank_cost = COST_ACT; uses_chan = 1'b0; end
            CMD_RD:  begin bank_cost = COST_RD;  uses_chan = 1'b1; end
            CMD_WR:  begin bank_cost = COST_WR;  uses_chan = 1'b1; end
            CMD_PRE: begin bank_cost = COST_PRE; uses_chan = 1'b0; end
            default: begin bank_cost = '0;       uses_chan = 1'b0; end
        endcase
        chan_cost = uses_chan ? COST_BUS : '0;
    end

    vt_scale #(.COST_W(COST_W), .MULT_W(MULT_W), .FRAC_W(FRAC_W), .TIME_W(TIME_W))
        u_bank_scale (.cost(bank_cost), .mult(mult), .scaled(bank_scaled));

    vt_scale #(.COST_W(COST_W), .MULT_W(MULT_W), .FRAC_W(FRAC_W), .TIME_W(TIME_W))
        u_chan_scale (.cost(chan_cost), .mult(mult), .scaled(chan_scaled));

    vt_state #(
        .NUM_THREADS(NUM_THREADS), .NUM_BANKS(NUM_BANKS), .TIME_W(TIME_W),
        .THR_W(THR_W), .BANK_W(BANK_W)
    ) u_state (
        .clk(clk), .rst_n(rst_n),
        .sel_thread(req_thread), .sel_bank(req_bank),
        .bank_q(bank_prev), .chan_q(chan_prev),
        .bank_we(req_valid), .chan_we(req_valid && uses_chan),
        .bank_d(bank_fin), .chan_d(chan_fin)
    );

    always_comb begin
        bank_start = (req_arrival > bank_prev) ? req_arrival : bank_prev;
        bank_fin   = bank_start + bank_scaled;
        chan_start = (bank_fin > chan_prev) ? bank_fin : chan_prev;
        chan_fin   = chan_start + chan_scaled;
        deadline   = uses_chan ? chan_fin : bank_fin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dl_valid <= 1'b0;
            dl_time  <= '0;
        end else begin
            dl_valid <= req_valid;
            if (req_valid) dl_time <= deadline;
        end
    end
endmodule

// File: rtl/vt_deadline_chk.sv
module vt_deadline_chk #(
    parameter int TIME_W = 16,
    parameter int THR_W  = 1,
    parameter int BANK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [THR_W-1:0]  req_thread,
    input logic [BANK_W-1:0] req_bank,
    input logic [1:0]        req_cmd,
    input logic [TIME_W-1:0] req_arrival,
    input logic              dl_valid,
    input logic [TIME_W-1:0] dl_time
);
    logic row_cmd;
    assign row_cmd = (req_cmd == 2'd0) || (req_cmd == 2'd3);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!dl_valid && dl_time == '0)); // R1

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> dl_valid); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!dl_valid && $stable(dl_time))); // R2

    AST_NOT_BEFORE_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (dl_time >= $past(req_arrival))); // R3

    AST_ROW_CHAIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(req_valid) && row_cmd
         && ($past(req_cmd) == 2'd0 || $past(req_cmd) == 2'd3)
         && req_thread == $past(req_thread) && req_bank == $past(req_bank))
        |=> (dl_time >= $past(dl_time))); // R9
endmodule

bind vt_deadline_calc vt_deadline_chk #(
    .TIME_W(TIME_W), .THR_W(THR_W), .BANK_W(BANK_W)
) u_chk (.*);

// File: tb/vt_deadline_calc_bench.sv
`timescale 1ns/1ps
module vt_deadline_calc_bench;
    localparam int TIME_W = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] share_inv;
    logic        req_valid = 1'b0;
    logic [0:0]  req_thread = '0;
    logic [1:0]  req_bank = '0;
    logic [1:0]  req_cmd = '0;
    logic [15:0] req_arrival = '0;
    logic        dl_valid;
    logic [15:0] dl_time;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    vt_deadline_calc u_vt_deadline_calc (
        .clk(clk), .rst_n(rst_n), .share_inv(share_inv),
        .req_valid(req_valid), .req_thread(req_thread), .req_bank(req_bank),
        .req_cmd(req_cmd), .req_arrival(req_arrival),
        .dl_valid(dl_valid), .dl_time(dl_time)
    );

    // {thread, bank, cmd, arrival, expected deadline}; thread0 x1.0, thread1 x2.0
    localparam int NV = 9;
    localparam logic [36:0] VEC [NV] = '{
        {1'b0, 2'd0, 2'd0, 16'd10,  16'd15},   // R7 activate, channel idle
        {1'b0, 2'd0, 2'd1, 16'd11,  16'd24},   // R3 R6 R9 read waits on bank
        {1'b0, 2'd1, 2'd2, 16'd12,  16'd28},   // R6 write waits on channel
        {1'b1, 2'd0, 2'd0, 16'd12,  16'd22},   // R8 thread1 bank0 starts fresh
        {1'b1, 2'd0, 2'd1, 16'd13,  16'd40},   // R5 doubled costs
        {1'b0, 2'd0, 2'd3, 16'd14,  16'd33},   // R4 precharge cost 13
        {1'b1, 2'd2, 2'd2, 16'd100, 16'd116},  // R3 arrival dominates
        {1'b0, 2'd3, 2'd1, 16'd5,   16'd32},   // R8 thread0 channel at 28
        {1'b0, 2'd0, 2'd0, 16'd40,  16'd45}    // R3 arrival beyond bank finish
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_req(input logic t, input logic [1:0] b, input logic [1:0] c,
                          input logic [15:0] arr, input logic [15:0] exp, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_thread = t; req_bank = b; req_cmd = c; req_arrival = arr;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid"}, 32'(dl_valid), 32'd1);
        check({req, " deadline"}, 32'(dl_time), 32'(exp));
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        share_inv = {16'h0200, 16'h0100};
        repeat (3) @(negedge clk);
        check("R1 reset valid", 32'(dl_valid), 32'd0);
        check("R1 reset time", 32'(dl_time), 32'd0);
        rst_n = 1'b1;

        // Back-to-back table
        for (int i = 0; i <= NV; i++) begin
            @(negedge clk);
            if (i > 0) begin
                check($sformatf("R9 vec%0d valid", i-1), 32'(dl_valid), 32'd1);
                check($sformatf("R3 R6 R7 vec%0d deadline", i-1), 32'(dl_time), 32'(VEC[i-1][15:0]));
            end
            if (i < NV) begin
                req_valid = 1'b1;
                req_thread = VEC[i][36];
                req_bank = VEC[i][35:34];
                req_cmd = VEC[i][33:32];
                req_arrival = VEC[i][31:16];
            end else begin
                req_valid = 1'b0;
            end
        end

        // Scaling and rounding
        share_inv[15:0] = 16'h0180;
        do_req(1'b0, 2'd2, 2'd2, 16'd200, 16'd212, "R5 x1.5 write");
        share_inv[15:0] = 16'h0155;
        do_req(1'b0, 2'd2, 2'd1, 16'd300, 16'd313, "R5 round-up read");
        share_inv[31:16] = 16'h0000;
        do_req(1'b1, 2'd1, 2'd0, 16'd500, 16'd500, "R5 zero multiplier");

        // Idle cycle holds
        @(negedge clk);
        check("R2 idle valid", 32'(dl_valid), 32'd0);
        check("R2 idle hold", 32'(dl_time), 32'd500);

        // Thread isolation: thread0 channel still at 313
        do_req(1'b0, 2'd1, 2'd1, 16'd0, 16'd319, "R8 thread0 channel kept");

        // Reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 mid reset valid", 32'(dl_valid), 32'd0);
        check("R1 mid reset time", 32'(dl_time), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        share_inv[15:0] = 16'h0100;
        do_req(1'b0, 2'd0, 2'd0, 16'd3, 16'd8, "R1 registers cleared");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule